// File: doc/BRIEF.md
# Paged Memory Chip-Select Decoder

This block sits between a microcontroller's 20-bit address bus and the devices behind it. It splits the address space into sixteen 64 KB pages and turns each bus access into at most one active-low chip select for a peripheral ASIC window, an EEPROM, an SRAM or a flash. Page 0 holds the controller's internal resources: vector tables, ROM, 2 KB of RAM and a 384-byte register block. No external select is driven for page 0.

Two pages can be moved at run time. Page 2 reaches either the EEPROM or the flash. Page 4 reaches either the flash or the SRAM. The choice comes from a two-bit configuration register inside the ASIC window. The register is written over the 8-bit data bus and takes its value on the rising edge of the write strobe. A write aimed at flash is refused: no flash select is driven, and a sticky error flag is raised that only reset clears. The read and write strobes also pass straight through to the memories as output and write enables.

Top module: `mcu_page_decode`

## Requirements
- R1: After reset, page 2 selects the EEPROM, page 4 selects the flash, and `wr_err` is 0.
- R2: An access to any address in page 0 (address bits [19:16] = 0) drives no chip select.
- R3: Page 1 drives `asic_cs_n` and page 3 drives `sram_cs_n`.
- R4: Page 2 drives `eeprom_cs_n` when configuration bit 0 is 0, and `flash_cs_n` when it is 1.
- R5: Page 4 drives `flash_cs_n` when configuration bit 1 is 0, and `sram_cs_n` when it is 1.
- R6: Pages 5 through 15 always decode to the flash.
- R7: A select is low only while `as_n` is low and at least one of `rd_n` or `wr_n` is low. At most one select is low at any time.
- R8: The configuration register lives at page 1, offset 0x0040 (parameter `CFG_OFFSET`). Data bits [1:0] are latched on the rising edge of `wr_n`. Writes to any other offset leave the configuration unchanged.
- R9: A write to a page that currently decodes to flash drives no flash select. It sets `wr_err` on the next clock, and `wr_err` stays set until reset.
- R10: `oe_n` follows `rd_n` and `we_n` follows `wr_n` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the strobes |
| rst_n | input | 1 | Active-low reset |
| addr | input | 20 | Microcontroller address bus |
| data_in | input | 8 | Write data from the microcontroller |
| as_n | input | 1 | Address strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable to the memories |
| we_n | output | 1 | Write enable to the memories |
| asic_cs_n | output | 1 | Peripheral ASIC window select |
| eeprom_cs_n | output | 1 | EEPROM select |
| sram_cs_n | output | 1 | SRAM select |
| flash_cs_n | output | 1 | Flash select |
| wr_err | output | 1 | Sticky flag: a write was aimed at flash |

## Verification
The hardest state to reach is a remapped page seen through the selects. The configuration only takes effect after a complete write cycle: the strobe is asserted for several clocks with a matching page-1 offset and then released while the address is still held. The stimulus performs exactly such writes, including one to a neighbouring offset that must be ignored, and then reads pages 2 and 4 to show where they now point. A write to page 2 made while it decodes to flash shows that the refusal of flash writes follows the remapping.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  localparam int PAGE_BITS = 4;
  localparam int NUM_SEL   = 4;

  // select bit order inside the one-hot vector
  localparam int SEL_ASIC   = 0;
  localparam int SEL_EEPROM = 1;
  localparam int SEL_SRAM   = 2;
  localparam int SEL_FLASH  = 3;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_ASIC,
    TGT_EEPROM,
    TGT_SRAM,
    TGT_FLASH
  } tgt_e;

  // page number plus the two remap bits -> destination
  function automatic tgt_e page_target(logic [PAGE_BITS-1:0] page,
                                       logic p2_flash, logic p4_sram);
    tgt_e t;
    case (page)
      4'h0:    t = TGT_NONE;
      4'h1:    t = TGT_ASIC;
      4'h2:    t = p2_flash ? TGT_FLASH : TGT_EEPROM;
      4'h3:    t = TGT_SRAM;
      4'h4:    t = p4_sram ? TGT_SRAM : TGT_FLASH;
      default: t = TGT_FLASH;
    endcase
    return t;
  endfunction

  function automatic logic [NUM_SEL-1:0] tgt_onehot(tgt_e t);
    logic [NUM_SEL-1:0] v;
    v = '0;
    case (t)
      TGT_ASIC:   v[SEL_ASIC]   = 1'b1;
      TGT_EEPROM: v[SEL_EEPROM] = 1'b1;
      TGT_SRAM:   v[SEL_SRAM]   = 1'b1;
      TGT_FLASH:  v[SEL_FLASH]  = 1'b1;
      default:    v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mpd_page_map.sv
module mpd_page_map
  import mpd_pkg::*;
(
  input  logic [PAGE_BITS-1:0] page,
  input  logic                 p2_flash,
  input  logic                 p4_sram,
  output tgt_e                 tgt
);
  always_comb tgt = page_target(page, p2_flash, p4_sram);
endmodule

// File: rtl/mpd_cfg_reg.sv
module mpd_cfg_reg #(
  parameter int CFG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             wr_n,
  input  logic [CFG_W-1:0] din,
  output logic [CFG_W-1:0] cfg,
  output logic             commit
);
  logic             wr_n_q;
  logic             hit_q;
  logic [CFG_W-1:0] din_q;

  // strobe released this cycle after being low the cycle before
  assign commit = wr_n & ~wr_n_q & hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
      hit_q  <= 1'b0;
      din_q  <= '0;
      cfg    <= '0;
    end else begin
      wr_n_q <= wr_n;
      if (!wr_n) begin
        hit_q <= hit;
        din_q <= din;
      end else begin
        hit_q <= 1'b0;
      end
      if (commit) cfg <= din_q;
    end
  end
endmodule

// File: rtl/mpd_sel_drive.sv
module mpd_sel_drive #(
  parameter int N = 4
) (
  input  logic         en,
  input  logic [N-1:0] onehot,
  input  logic [N-1:0] mask,
  output logic [N-1:0] cs_n
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign cs_n[i] = ~(en & onehot[i] & ~mask[i]);
  end
endmodule

// File: rtl/mcu_page_decode.sv
module mcu_page_decode
  import mpd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 8,
  parameter int CFG_OFFSET = 'h0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              as_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              asic_cs_n,
  output logic              eeprom_cs_n,
  output logic              sram_cs_n,
  output logic              flash_cs_n,
  output logic              wr_err
);
  localparam int OFF_W = ADDR_W - PAGE_BITS;
  localparam logic [OFF_W-1:0] CFG_OFF = OFF_W'(CFG_OFFSET);
  localparam int CFG_W = 2;

  logic [PAGE_BITS-1:0] page;
  logic [OFF_W-1:0]     offset;
  logic [CFG_W-1:0]     cfg;
  logic                 cfg_hit;
  logic                 cfg_commit;
  logic                 access;
  logic                 flash_wr;
  tgt_e                 tgt;
  logic [NUM_SEL-1:0]   onehot;
  logic [NUM_SEL-1:0]   mask;
  logic [NUM_SEL-1:0]   cs_n;
  logic                 unused_data;

  assign page        = addr[ADDR_W-1 -: PAGE_BITS];
  assign offset      = addr[OFF_W-1:0];
  assign unused_data = ^data_in[DATA_W-1:CFG_W];

  assign cfg_hit  = ~as_n & (page == PAGE_BITS'(1)) & (offset == CFG_OFF);
  assign access   = ~as_n & (~rd_n | ~wr_n);
  assign flash_wr = ~as_n & ~wr_n & (tgt == TGT_FLASH);
  assign onehot   = tgt_onehot(tgt);

  always_comb begin
    mask            = '0;
    mask[SEL_FLASH] = ~wr_n;
  end

  mpd_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (cfg_hit),
    .wr_n   (wr_n),
    .din    (data_in[CFG_W-1:0]),
    .cfg    (cfg),
    .commit (cfg_commit)
  );

  mpd_page_map u_map (
    .page     (page),
    .p2_flash (cfg[0]),
    .p4_sram  (cfg[1]),
    .tgt      (tgt)
  );

  mpd_sel_drive #(.N(NUM_SEL)) u_sel (
    .en     (access),
    .onehot (onehot),
    .mask   (mask),
    .cs_n   (cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_err <= 1'b0;
    else if (flash_wr) wr_err <= 1'b1;
  end

  assign asic_cs_n   = cs_n[SEL_ASIC];
  assign eeprom_cs_n = cs_n[SEL_EEPROM];
  assign sram_cs_n   = cs_n[SEL_SRAM];
  assign flash_cs_n  = cs_n[SEL_FLASH];
  assign oe_n        = rd_n;
  assign we_n        = wr_n;
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] page,
  input logic       as_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       asic_cs_n,
  input logic       eeprom_cs_n,
  input logic       sram_cs_n,
  input logic       flash_cs_n,
  input logic       wr_err,
  input logic       cfg_commit
);
  logic [3:0] sel;
  assign sel = ~{asic_cs_n, eeprom_cs_n, sram_cs_n, flash_cs_n};

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) <= 1); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n || (rd_n && wr_n)) |-> (sel == 4'b0)); // R7
  AST_PAGE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (page == 4'h0) |-> (sel == 4'b0)); // R2
  AST_PAGE1_ASIC: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !rd_n && page == 4'h1) |-> !asic_cs_n); // R3
  AST_HIGH_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !rd_n && wr_n && page >= 4'h5) |-> !flash_cs_n); // R6
  AST_NO_FLASH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> flash_cs_n); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err); // R9
  AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |-> (wr_n && !$past(wr_n))); // R8
endmodule

bind mcu_page_decode mpd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .page        (addr[19:16]),
  .as_n        (as_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .asic_cs_n   (asic_cs_n),
  .eeprom_cs_n (eeprom_cs_n),
  .sram_cs_n   (sram_cs_n),
  .flash_cs_n  (flash_cs_n),
  .wr_err      (wr_err),
  .cfg_commit  (cfg_commit)
);

// File: tb/sim_mcu_page_decode.sv
module sim_mcu_page_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic [7:0]  data_in = '0;
  logic        as_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        oe_n, we_n, asic_cs_n, eeprom_cs_n, sram_cs_n, flash_cs_n, wr_err;

  int checks = 0;
  int fails  = 0;
  logic m_p2f = 1'b0;  // bench model of config bit 0
  logic m_p4s = 1'b0;  // bench model of config bit 1

  always #4 clk = ~clk;

  mcu_page_decode u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .as_n(as_n), .rd_n(rd_n), .wr_n(wr_n), .oe_n(oe_n), .we_n(we_n),
    .asic_cs_n(asic_cs_n), .eeprom_cs_n(eeprom_cs_n), .sram_cs_n(sram_cs_n),
    .flash_cs_n(flash_cs_n), .wr_err(wr_err)
  );

  // expected active-high selects {asic, eeprom, sram, flash}
  function automatic logic [3:0] want_sel(logic [3:0] pg, logic is_wr);
    logic [3:0] r;
    if (pg == 4'd0)      r = 4'b0000;
    else if (pg == 4'd1) r = 4'b1000;
    else if (pg == 4'd3) r = 4'b0010;
    else if (pg == 4'd2) r = m_p2f ? 4'b0001 : 4'b0100;
    else if (pg == 4'd4) r = m_p4s ? 4'b0010 : 4'b0001;
    else                 r = 4'b0001;
    if (is_wr) r[0] = 1'b0;
    return r;
  endfunction

  function automatic logic [3:0] got_sel();
    return ~{asic_cs_n, eeprom_cs_n, sram_cs_n, flash_cs_n};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    as_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic read_at(string req, logic [19:0] a);
    @(negedge clk);
    addr = a; as_n = 1'b0; rd_n = 1'b0;
    #1;
    check(req, {4'h0, got_sel()}, {4'h0, want_sel(a[19:16], 1'b0)});
    idle();
  endtask

  task automatic write_at(logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; data_in = d; as_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    as_n = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_p2f = 1'b0; m_p4s = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R1 err after reset", {7'h0, wr_err}, 8'h0);
    read_at("R1 page2 default", 20'h2_0010);
    read_at("R1 page4 default", 20'h4_0010);
  endtask

  task automatic t_page0();
    read_at("R2 vectors", 20'h0_0000);
    read_at("R2 ram", 20'h0_F680);
    read_at("R2 regs", 20'h0_FE80);
  endtask

  task automatic t_qualify();
    @(negedge clk);
    addr = 20'h3_0000; as_n = 1'b1; rd_n = 1'b0; #1;
    check("R7 no as_n", {4'h0, got_sel()}, 8'h0);
    @(negedge clk);
    as_n = 1'b0; rd_n = 1'b1; wr_n = 1'b1; #1;
    check("R7 no strobe", {4'h0, got_sel()}, 8'h0);
    idle();
  endtask

  task automatic t_fixed_pages();
    read_at("R3 page1 asic", 20'h1_1234);
    read_at("R3 page3 sram", 20'h3_7FFF);
    for (int p = 5; p < 16; p++) read_at("R6 high page", {p[3:0], 16'hABCD});
  endtask

  task automatic t_remap();
    write_at(20'h1_0040, 8'h03);
    m_p2f = 1'b1; m_p4s = 1'b1;
    read_at("R4 page2 flash", 20'h2_0000);
    read_at("R5 page4 sram", 20'h4_0000);
    write_at(20'h1_0041, 8'h00);
    read_at("R8 wrong offset page2", 20'h2_0000);
    read_at("R8 wrong offset page4", 20'h4_0000);
    write_at(20'h1_0040, 8'h02);
    m_p2f = 1'b0; m_p4s = 1'b1;
    read_at("R4 page2 eeprom", 20'h2_0000);
    read_at("R5 page4 sram kept", 20'h4_0000);
  endtask

  task automatic t_write_err();
    @(negedge clk);
    addr = 20'h3_0100; as_n = 1'b0; wr_n = 1'b0; #1;
    check("R9 sram write select", {4'h0, got_sel()}, 8'h02);
    check("R10 pass through", {6'h0, oe_n, we_n}, {6'h0, rd_n, wr_n});
    idle();
    @(negedge clk);
    check("R9 no err on sram", {7'h0, wr_err}, 8'h0);
    write_at(20'h1_0040, 8'h01);
    m_p2f = 1'b1; m_p4s = 1'b0;
    @(negedge clk);
    addr = 20'h2_0200; as_n = 1'b0; wr_n = 1'b0; #1;
    check("R9 flash write no select", {4'h0, got_sel()}, 8'h00);
    @(negedge clk);
    check("R9 err set", {7'h0, wr_err}, 8'h1);
    idle();
    read_at("R9 read after err", 20'h7_0000);
    check("R9 err sticky", {7'h0, wr_err}, 8'h1);
    do_reset();
    check("R1 err cleared", {7'h0, wr_err}, 8'h0);
    read_at("R1 page2 after reset", 20'h2_0000);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_page0();
    t_qualify();
    t_fixed_pages();
    t_remap();
    t_write_err();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule